// File: doc/BRIEF.md
# Rectangle Blit Engine

This engine copies a rectangle of pixels from one bitmap surface to another inside a frame memory made of `DW`-bit words. Each surface has a base word address, a raster width in pixels and a colour depth of 1, 2, 4, 8 or 16 bits per pixel. The engine converts every pixel coordinate into a word address and a bit offset. Source and destination can therefore sit at any pixel position, including positions inside a word at the packed low depths. It also copies correctly when both rectangles lie on the same surface, for example when scrolling text up or sliding a 1-bit image left by one pixel.

Software sets up the surfaces, the source rectangle and the option flags on level inputs. It then issues a draw-at command carrying the destination corner. The settings are captured when that command is accepted. The engine then walks the rectangle pixel by pixel. For each pixel it reads the source word, reads the destination word and writes that word back with only the target pixel's bits replaced. All of this goes through a single request/grant memory port that allows one read in flight at a time.

Top module: `rect_blit`

## Requirements
- R1: Depth code d (0 to 4) means 2^d bits per pixel. Pixel (x, y) of a surface lies at bit position P = (y*pitch + x)*2^d counted from the surface base. Its word is base + P/DW, and the pixel occupies bits [P mod DW +: 2^d] of that word, so the pixel with the lowest x in a word sits at the least significant bits.
- R2: With only the enable flag set, the source pixel at (rect_x+i, rect_y+j) is copied to the destination pixel (cmd_x+i, cmd_y+j) for every i < rect_w and j < rect_h, and no other destination pixel changes.
- R3: A command is accepted on a clock edge where cmd_valid and cmd_ready are both high. All surface, rectangle and flag inputs are captured on that edge, and busy is high in the following cycle when a copy results.
- R4: Pixels are handled in rows of increasing y, and within a row by increasing x. A copy on one surface whose destination lies above the source (for example source (0,16) to destination (0,0)) therefore moves the image up intact.
- R5: At 1, 2 and 4 bits per pixel, source and destination may start at any pixel, including positions inside a word, so a one-pixel horizontal shift works.
- R6: Every destination write is a read-modify-write of the destination word. Only the target pixel's bits change.
- R7: When the depths differ, the source value is cut to its low destination-depth bits or padded with zeros at the top.
- R8: With the mask flag set, a source pixel of value zero leaves its destination pixel untouched, and no write is issued for it.
- R9: The mirror flag reverses the order in which source columns are read, and the flip flag reverses the order of source rows. The destination walk is unchanged.
- R10: A command accepted with the enable flag clear, or with a zero width or height, writes nothing and leaves busy low.
- R11: Busy stays high until the last pixel completes, and cmd_ready is low for as long as busy is high. A command held during that time is accepted once the engine is idle again.
- R12: A memory request stays asserted, with the same address and direction, until it is granted. At most one read is in flight, and the port is quiet while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_base | input | AW | Source surface base word address |
| src_pitch | input | CW | Source raster width in pixels |
| src_depth | input | 3 | Source depth code (0 to 4) |
| dst_base | input | AW | Destination surface base word address |
| dst_pitch | input | CW | Destination raster width in pixels |
| dst_depth | input | 3 | Destination depth code (0 to 4) |
| rect_x | input | CW | Source rectangle left pixel |
| rect_y | input | CW | Source rectangle top row |
| rect_w | input | CW | Copy width in pixels |
| rect_h | input | CW | Copy height in rows |
| cfg_enable | input | 1 | Copy enable |
| cfg_mask | input | 1 | Skip zero-valued source pixels |
| cfg_mirror | input | 1 | Read source columns right to left |
| cfg_flip | input | 1 | Read source rows bottom to top |
| cmd_valid | input | 1 | Draw-at command request |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_x | input | CW | Destination corner x |
| cmd_y | input | CW | Destination corner y |
| busy | output | 1 | Copy in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |

## Verification
A wrong coordinate counter or a wrong bit-offset calculation shows up as a wrong write address or a wrong write word. The bench compares each write against the reference model in the very cycle it is granted, so such a fault is caught at the first affected pixel rather than at the end of the copy. A write-back that uses a stale or wrongly merged destination word alters bits next to the target pixel, and the same per-write comparison exposes it. A state machine that drops busy early, or that lets a new command in while copying, is caught through cmd_ready and busy, which the bench samples every cycle while a second command waits. At the end of every copy, the bench compares the whole memory image with the model.

// File: rtl/rect_blit.sv
module rect_blit #(
  parameter int DW = 16,
  parameter int AW = 20,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] src_base,
  input  logic [CW-1:0] src_pitch,
  input  logic [2:0]    src_depth,
  input  logic [AW-1:0] dst_base,
  input  logic [CW-1:0] dst_pitch,
  input  logic [2:0]    dst_depth,
  input  logic [CW-1:0] rect_x,
  input  logic [CW-1:0] rect_y,
  input  logic [CW-1:0] rect_w,
  input  logic [CW-1:0] rect_h,
  input  logic          cfg_enable,
  input  logic          cfg_mask,
  input  logic          cfg_mirror,
  input  logic          cfg_flip,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [CW-1:0] cmd_x,
  input  logic [CW-1:0] cmd_y,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  localparam int OW = $clog2(DW);
  localparam int BW = 2*CW + 5;

  typedef enum logic [2:0] {IDLE, RD_SRC, WT_SRC, RD_DST, WT_DST, WR_DST} st_t;
  st_t st;

  logic [AW-1:0] s_base, d_base;
  logic [CW-1:0] s_pitch, d_pitch, rx, ry, rw, rh, dx, dy, ci, rj;
  logic [2:0]    s_dep, d_dep;
  logic          msk, mir, flp;
  logic [DW-1:0] pix, dword;

  function automatic logic [DW-1:0] pmask(input logic [2:0] dep);
    return ~({DW{1'b1}} << (6'd1 << dep));
  endfunction

  function automatic logic [BW-1:0] bitpos(input logic [CW-1:0] x, input logic [CW-1:0] y,
                                           input logic [CW-1:0] pitch, input logic [2:0] dep);
    return (BW'(y) * BW'(pitch) + BW'(x)) << dep;
  endfunction

  logic [CW-1:0] sx, sy;
  logic [BW-1:0] s_bp, d_bp;
  logic [AW-1:0] s_addr, d_addr;
  logic [DW-1:0] src_pix, d_msk;
  logic          col_last, row_last, step;

  assign sx = rx + (mir ? (rw - 1'b1 - ci) : ci);
  assign sy = ry + (flp ? (rh - 1'b1 - rj) : rj);
  assign s_bp = bitpos(sx, sy, s_pitch, s_dep);
  assign d_bp = bitpos(dx + ci, dy + rj, d_pitch, d_dep);
  assign s_addr = s_base + AW'(s_bp >> OW);
  assign d_addr = d_base + AW'(d_bp >> OW);
  assign src_pix = (mem_rdata >> s_bp[OW-1:0]) & pmask(s_dep);
  assign d_msk = pmask(d_dep) << d_bp[OW-1:0];

  assign col_last = (ci == rw - 1'b1);
  assign row_last = (rj == rh - 1'b1);
  assign step = (st == WT_SRC && mem_rvalid && msk && src_pix == '0) ||
                (st == WR_DST && mem_gnt);

  assign busy      = (st != IDLE);
  assign cmd_ready = !busy;
  assign mem_req   = (st == RD_SRC) || (st == RD_DST) || (st == WR_DST);
  assign mem_we    = (st == WR_DST);
  assign mem_addr  = (st == RD_SRC) ? s_addr : d_addr;
  assign mem_wdata = (dword & ~d_msk) | (((pix & pmask(d_dep))) << d_bp[OW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      {s_base, d_base} <= '0;
      {s_pitch, d_pitch, rx, ry, rw, rh, dx, dy, ci, rj} <= '0;
      {s_dep, d_dep, msk, mir, flp} <= '0;
      pix <= '0;
      dword <= '0;
    end else begin
      case (st)
        IDLE: if (cmd_valid) begin
          s_base <= src_base;  s_pitch <= src_pitch;  s_dep <= src_depth;
          d_base <= dst_base;  d_pitch <= dst_pitch;  d_dep <= dst_depth;
          rx <= rect_x;  ry <= rect_y;  rw <= rect_w;  rh <= rect_h;
          dx <= cmd_x;   dy <= cmd_y;
          msk <= cfg_mask;  mir <= cfg_mirror;  flp <= cfg_flip;
          ci <= '0;  rj <= '0;
          if (cfg_enable && rect_w != '0 && rect_h != '0) st <= RD_SRC;
        end
        RD_SRC: if (mem_gnt) st <= WT_SRC;
        WT_SRC: if (mem_rvalid) begin
          pix <= src_pix;
          if (step) st <= (col_last && row_last) ? IDLE : RD_SRC;
          else      st <= RD_DST;
        end
        RD_DST: if (mem_gnt) st <= WT_DST;
        WT_DST: if (mem_rvalid) begin
          dword <= mem_rdata;
          st <= WR_DST;
        end
        WR_DST: if (mem_gnt) st <= (col_last && row_last) ? IDLE : RD_SRC;
        default: st <= IDLE;
      endcase
      if (step) begin
        if (col_last) begin
          ci <= '0;
          rj <= rj + 1'b1;
        end else begin
          ci <= ci + 1'b1;
        end
      end
    end
  end
endmodule

module rect_blit_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_gnt,
  input logic          mem_rvalid
);
  logic rd_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          rd_pend <= 1'b0;
    else if (mem_req && mem_gnt && !mem_we) rd_pend <= 1'b1;
    else if (mem_rvalid)                 rd_pend <= 1'b0;
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R12
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> !mem_req);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R3
  start_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid && cmd_ready));

  // R11
  end_after_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past((mem_req && mem_gnt && mem_we) || mem_rvalid));
endmodule

bind rect_blit rect_blit_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
  .mem_rvalid(mem_rvalid)
);

// File: tb/rect_blit_tb.sv
module rect_blit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 20;
  localparam int CW = 12;

  logic clk, rst_n;
  logic [AW-1:0] src_base, dst_base;
  logic [CW-1:0] src_pitch, dst_pitch, rect_x, rect_y, rect_w, rect_h, cmd_x, cmd_y;
  logic [2:0] src_depth, dst_depth;
  logic cfg_enable, cfg_mask, cfg_mirror, cfg_flip, cmd_valid, cmd_ready, busy;
  logic mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  rect_blit #(.DW(DW), .AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .src_base(src_base), .src_pitch(src_pitch), .src_depth(src_depth),
    .dst_base(dst_base), .dst_pitch(dst_pitch), .dst_depth(dst_depth),
    .rect_x(rect_x), .rect_y(rect_y), .rect_w(rect_w), .rect_h(rect_h),
    .cfg_enable(cfg_enable), .cfg_mask(cfg_mask), .cfg_mirror(cfg_mirror), .cfg_flip(cfg_flip),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_x(cmd_x), .cmd_y(cmd_y),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  logic [15:0] mem   [0:4095];
  logic [15:0] exp_m [0:4095];
  int    eq_a[$];
  int    eq_d[$];
  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string cur_tag = "R12";
  logic  ld_en;
  logic [11:0] ld_addr;
  logic [15:0] ld_data;
  logic [7:0]  lfsr;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    if (!rst_n) begin
      lfsr <= 8'h5b;
      mem_gnt <= 1'b0;
      mem_rvalid <= 1'b0;
      mem_rdata <= '0;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_gnt <= lfsr[0] | lfsr[2];
      mem_rvalid <= mem_req && mem_gnt && !mem_we;
      if (mem_req && mem_gnt) begin
        if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[11:0]];
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      summary();
    end
  end

  // per-clock comparison of each granted write against the model (R1 R2 R6)
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_gnt && mem_we) begin
      checks++;
      if (eq_a.size() == 0) begin
        errors++;
        $display("FAIL %s: write addr %0d data %h, expected no write", cur_tag, mem_addr, mem_wdata);
      end else begin
        int a, d;
        a = eq_a.pop_front();
        d = eq_d.pop_front();
        if (int'(mem_addr) != a || int'(mem_wdata) != d) begin
          errors++;
          $display("FAIL %s: write addr %0d data %h, expected addr %0d data %h",
                   cur_tag, mem_addr, mem_wdata, a, d[15:0]);
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] pat(input int a);
    int v;
    v = (a * 40503 + 4660) ^ (a << 7);
    if (a % 3 == 0) v = v & 16'hF0F0;
    return v[15:0];
  endfunction

  task automatic model(input int sb, sp, sd, db, dp, dd, rx, ry, w, h, dx, dy,
                       input bit en, mk, mi, fl);
    if (!en) return;
    for (int j = 0; j < h; j++) begin
      for (int i = 0; i < w; i++) begin
        int sx, sy, ba, a, o, p, smask, dmask, wd;
        sx = rx + (mi ? w - 1 - i : i);
        sy = ry + (fl ? h - 1 - j : j);
        ba = (sy * sp + sx) << sd;
        a = sb + ba / 16;
        o = ba % 16;
        smask = (1 << (1 << sd)) - 1;
        p = (int'(exp_m[a]) >> o) & smask;
        if (!(mk && p == 0)) begin
          dmask = (1 << (1 << dd)) - 1;
          p = p & dmask;
          ba = ((dy + j) * dp + dx + i) << dd;
          a = db + ba / 16;
          o = ba % 16;
          wd = (int'(exp_m[a]) & ~(dmask << o)) | (p << o);
          exp_m[a] = wd[15:0];
          eq_a.push_back(a);
          eq_d.push_back(wd & 16'hFFFF);
        end
      end
    end
  endtask

  task automatic setup(input int sb, sp, sd, db, dp, dd, rx, ry, w, h, dx, dy,
                       input bit en, mk, mi, fl);
    src_base = AW'(sb); src_pitch = CW'(sp); src_depth = 3'(sd);
    dst_base = AW'(db); dst_pitch = CW'(dp); dst_depth = 3'(dd);
    rect_x = CW'(rx); rect_y = CW'(ry); rect_w = CW'(w); rect_h = CW'(h);
    cmd_x = CW'(dx); cmd_y = CW'(dy);
    cfg_enable = en; cfg_mask = mk; cfg_mirror = mi; cfg_flip = fl;
    model(sb, sp, sd, db, dp, dd, rx, ry, w, h, dx, dy, en, mk, mi, fl);
  endtask

  task automatic finish_check(input string tag);
    int bad;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check({tag, " pending writes"}, eq_a.size(), 0);
    bad = 0;
    for (int a = 0; a < 4096; a++) if (mem[a] !== exp_m[a]) bad++;
    check({tag, " memory image mismatches"}, bad, 0);
  endtask

  task automatic blit(input string tag, input int sb, sp, sd, db, dp, dd, rx, ry, w, h, dx, dy,
                      input bit en, mk, mi, fl, input bit exp_busy);
    @(negedge clk);
    cur_tag = tag;
    setup(sb, sp, sd, db, dp, dd, rx, ry, w, h, dx, dy, en, mk, mi, fl);
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check({tag, " R3 busy after accept"}, int'(busy), int'(exp_busy));
    finish_check(tag);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    src_base = '0; dst_base = '0; src_pitch = '0; dst_pitch = '0; src_depth = '0; dst_depth = '0;
    rect_x = '0; rect_y = '0; rect_w = '0; rect_h = '0; cmd_x = '0; cmd_y = '0;
    cfg_enable = 1'b0; cfg_mask = 1'b0; cfg_mirror = 1'b0; cfg_flip = 1'b0;
    for (int a = 0; a < 4096; a++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 12'(a); ld_data = pat(a);
      exp_m[a] = pat(a);
    end
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    // R11 R12: reset state
    check("R11 busy in reset", int'(busy), 0);
    check("R11 ready in reset", int'(cmd_ready), 1);
    check("R12 no request in reset", int'(mem_req), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 idle after reset", int'(mem_req), 0);

    // R4 scroll up 16 lines on one 8bpp surface
    blit("R4", 100, 16, 3, 100, 16, 3, 0, 16, 16, 8, 0, 0, 1, 0, 0, 0, 1);
    // R5 R6 one-pixel left shift at 1bpp, same surface
    blit("R5,R6", 400, 32, 0, 400, 32, 0, 1, 0, 31, 4, 0, 0, 1, 0, 0, 0, 1);
    // R5 2bpp odd offsets between surfaces
    blit("R5", 1000, 20, 1, 1100, 28, 1, 3, 1, 9, 3, 5, 2, 1, 0, 0, 0, 1);
    // R7 4bpp to 2bpp truncation
    blit("R7", 600, 8, 2, 700, 24, 1, 3, 1, 5, 3, 5, 2, 1, 0, 0, 0, 1);
    // R7 2bpp to 8bpp zero extension
    blit("R7", 1200, 16, 1, 1300, 12, 3, 2, 0, 6, 2, 1, 1, 1, 0, 0, 0, 1);
    // R1 R2 16bpp plain copy
    blit("R1,R2", 800, 10, 4, 900, 10, 4, 2, 2, 4, 3, 7, 1, 1, 0, 0, 0, 1);
    // R8 transparency at 4bpp
    blit("R8", 1500, 16, 2, 1600, 16, 2, 0, 0, 16, 3, 0, 0, 1, 1, 0, 0, 1);
    // R9 mirror and flip at 8bpp
    blit("R9", 1700, 8, 3, 1800, 8, 3, 1, 1, 5, 3, 2, 0, 1, 0, 1, 1, 1);
    blit("R9", 1700, 8, 3, 1900, 8, 3, 0, 0, 4, 2, 0, 0, 1, 0, 1, 0, 1);
    // R10 enable clear and zero size
    blit("R10", 100, 16, 3, 2000, 16, 3, 0, 0, 4, 4, 0, 0, 0, 0, 0, 0, 0);
    blit("R10", 100, 16, 3, 2000, 16, 3, 0, 0, 0, 4, 0, 0, 1, 0, 0, 0, 0);
    blit("R10", 100, 16, 3, 2000, 16, 3, 0, 0, 4, 0, 0, 0, 1, 0, 0, 0, 0);

    // R11 second command held while busy, R3 settings captured at accept
    begin
      int ready_seen, n;
      @(negedge clk);
      cur_tag = "R11";
      setup(2100, 16, 3, 2200, 16, 3, 0, 0, 6, 2, 1, 1, 1, 0, 0, 0);
      cmd_valid = 1'b1;
      @(negedge clk);
      check("R11 busy after first accept", int'(busy), 1);
      setup(2300, 8, 2, 2400, 8, 2, 1, 0, 5, 2, 0, 1, 1, 0, 0, 0);
      ready_seen = 0; n = 0;
      while (busy) begin
        if (cmd_ready) ready_seen++;
        n++;
        @(negedge clk);
      end
      check("R11 ready low while busy", ready_seen, 0);
      check("R11 first copy took cycles", int'(n > 12), 1);
      @(negedge clk);
      check("R11 held command started", int'(busy), 1);
      cmd_valid = 1'b0;
      finish_check("R11");
    end
    summary();
  end
endmodule